// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Address Filter

This block is an asynchronous serial transmitter and receiver for a shared bus. Each side has a 16-entry queue. A fractional rate generator produces a sampling tick at sixteen times the bit rate. The clock divisor is an integer, and a small add/modulus pair stretches selected ticks by one clock, so the average rate can hit standard values from an arbitrary input clock. Frames are a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a high stop bit.

In nine-bit mode a set ninth bit marks an address frame. Two filter modes are available. In hardware filtering, the receiver drops traffic until an address frame carries the local node address, keeps data frames after that, and stops keeping them at the next foreign address. In software filtering, every frame is queued and address frames raise a sticky flag. Software reaches the block through a small word-wide register port. An interrupt request rises when the receive queue holds at least a chosen number of entries. A pause bit holds the transmitter idle between frames, which gives software flow control.

Register map (3-bit address):
- 0: data. A write queues bits 8:0 for sending. A read returns the oldest received word in bits 8:0 and removes it.
- 1: line control. Bit 0 enables nine-bit mode, bit 1 selects hardware address filtering, bit 2 pauses the transmitter, and bits 4:3 select the interrupt level.
- 2: node address in bits 7:0.
- 3: integer divisor.
- 4: fraction. The stretch count is in bits 3:0 and the modulus in bits 7:4.
- 5: status.

Top module: `uart9_core`

## Requirements
- R1: After reset tx_o is 1, irq_o is 0, and status reads 0x0020.
- R2: A frame is a start bit of 0, then the data bits least significant bit first (8, or 9 in nine-bit mode, bit 8 last), then a stop bit of 1. Each bit lasts 16 ticks, and a tick occurs every divisor clocks when the stretch count is 0. With divisor 1, the eight-bit frame of 0x00 holds tx_o low for 144 clocks.
- R3: With stretch count A below modulus M, A of every M ticks last one extra clock. With divisor 2, A=1 and M=2, the 0x00 frame holds tx_o low for 360 clocks.
- R4: Received words are read back in arrival order. The receive queue holds 16 words, and its count is status bits 12:8.
- R5: A frame that arrives when the receive queue is full is discarded and sets status bit 2. The words already queued are unchanged.
- R6: A stop bit sampled low sets status bit 3, and the word is still queued.
- R7: irq_o is 1 exactly while the receive count is at or above the selected level. Line bits 4:3 select the level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R8: With hardware filtering in nine-bit mode, address frames are never queued. Data frames are queued only after an address frame equal to the node address and before the next address frame that differs from it.
- R9: With software filtering in nine-bit mode, every frame is queued with its ninth bit in bit 8, and an address frame sets status bit 4.
- R10: While line bit 2 is set, no new frame starts and tx_o stays 1. Queued words go out once the bit is cleared.
- R11: The transmit queue holds 16 words. Status bit 1 shows it full, and a write to a full queue is dropped.
- R12: Writing 1 to status bits 2, 3 or 4 clears that bit. Status bit 0 means the receive queue is not empty, and bit 5 means the transmitter is idle with an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive queue at address 0) |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, combinational from address |
| irq_o | output | 1 | Receive level interrupt request |
| tx_o | output | 1 | Serial transmit line |
| rx_i | input | 1 | Serial receive line |

## Verification
A register write takes effect at the next clock edge. Status and irq_o follow the receive count in the same cycle, so the bench samples them at the falling edge after the write or read strobe. The transmit line falls one clock after the first tick that follows the queue write, and each bit then lasts 16 ticks. The bench therefore finds the falling edge of tx_o and samples each bit 8 clocks into it, and it measures low time by counting falling clock edges. A received word is queued three clocks after the middle of its stop bit: two synchroniser stages and one output register. Before it reads anything back, the bench waits until the transmitter reports idle and then allows a fixed margin of 40 clocks.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_LINE = 3'd1,
    A_NODE = 3'd2,
    A_DIV  = 3'd3,
    A_FRAC = 3'd4,
    A_STAT = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

  function automatic logic [3:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      2'd2:    return 4'd8;
      default: return 4'd14;
    endcase
  endfunction
endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] add_i,
  input  logic [FRAC_W-1:0] mul_i,
  output logic              tick_o
);
  logic [DIV_W:0]  cnt_q, limit;
  logic [FRAC_W:0] acc_q, acc_sum;
  logic [DIV_W-1:0] div_eff;
  logic stretch_q, frac_on;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign limit   = {1'b0, div_eff} - (DIV_W+1)'(1) + (DIV_W+1)'(stretch_q);
  assign frac_on = (mul_i != '0) && (add_i < mul_i);
  assign acc_sum = acc_q + {1'b0, add_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      stretch_q <= 1'b0;
      tick_o    <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (cnt_q >= limit) begin
        cnt_q  <= '0;
        tick_o <= 1'b1;
        if (frac_on && acc_sum >= {1'b0, mul_i}) begin
          acc_q     <= acc_sum - {1'b0, mul_i};
          stretch_q <= 1'b1;
        end else begin
          acc_q     <= frac_on ? acc_sum : '0;
          stretch_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q + (DIV_W+1)'(1);
      end
    end
  end
endmodule

// File: rtl/uart9_fifo.sv
module uart9_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic push_ok, pop_ok;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   count_o <= count_o + CNT_W'(1);
        2'b01:   count_o <= count_o - CNT_W'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       nine_i,
  input  logic       pause_i,
  input  logic       valid_i,
  input  logic [8:0] data_i,
  output logic       pop_o,
  output logic       busy_o,
  output logic       tx_o
);
  logic [10:0] sh_q;
  logic [3:0]  sub_q, left_q;

  assign pop_o = tick_i && !busy_o && valid_i && !pause_i;
  assign tx_o  = busy_o ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      sub_q  <= '0;
      left_q <= '0;
      busy_o <= 1'b0;
    end else if (pop_o) begin
      sh_q   <= nine_i ? {1'b1, data_i[8], data_i[7:0], 1'b0}
                       : {2'b11, data_i[7:0], 1'b0};
      left_q <= nine_i ? 4'd11 : 4'd10;
      sub_q  <= '0;
      busy_o <= 1'b1;
    end else if (busy_o && tick_i) begin
      if (sub_q == 4'd15) begin
        sub_q  <= '0;
        sh_q   <= {1'b1, sh_q[10:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_o <= 1'b0;
      end else begin
        sub_q <= sub_q + 4'd1;
      end
    end
  end
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       nine_i,
  input  logic       rx_i,
  output logic       valid_o,
  output logic [8:0] data_o,
  output logic       ferr_o
);
  rx_state_e   st_q;
  logic        s1_q, s2_q;
  logic [3:0]  sub_q, cnt_q, last_idx;
  logic [8:0]  sh_q;

  assign last_idx = nine_i ? 4'd8 : 4'd7;
  assign data_o   = nine_i ? sh_q : {1'b0, sh_q[8:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      st_q    <= RX_IDLE;
      sub_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      s1_q    <= rx_i;
      s2_q    <= s1_q;
      valid_o <= 1'b0;
      if (tick_i) begin
        case (st_q)
          RX_IDLE: if (!s2_q) begin
            st_q  <= RX_START;
            sub_q <= '0;
          end
          RX_START: if (sub_q == 4'd7) begin
            st_q  <= s2_q ? RX_IDLE : RX_DATA;
            sub_q <= '0;
            cnt_q <= '0;
          end else sub_q <= sub_q + 4'd1;
          RX_DATA: if (sub_q == 4'd15) begin
            sub_q <= '0;
            sh_q  <= {s2_q, sh_q[8:1]};
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == last_idx) st_q <= RX_STOP;
          end else sub_q <= sub_q + 4'd1;
          RX_STOP: if (sub_q == 4'd15) begin
            valid_o <= 1'b1;
            ferr_o  <= !s2_q;
            st_q    <= RX_IDLE;
            sub_q   <= '0;
          end else sub_q <= sub_q + 4'd1;
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart9_core.sv
module uart9_core
  import uart9_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        irq_o,
  output logic        tx_o,
  input  logic        rx_i
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [4:0]        line_q;
  logic [7:0]        node_q;
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] add_q, mul_q;
  logic ovr_q, ferr_q, adr_q, match_q;

  logic nine_en, auto_en, tx_pause;
  logic [1:0] trig_sel;
  assign nine_en  = line_q[0];
  assign auto_en  = line_q[1];
  assign tx_pause = line_q[2];
  assign trig_sel = line_q[4:3];

  logic tick, tx_push, tx_pop, tx_busy, tx_full, tx_empty;
  logic [8:0] tx_head;
  logic [CNT_W-1:0] tx_count;
  logic rx_valid, rx_ferr, rx_push, rx_pop, rx_full, rx_empty, is_addr, keep;
  logic [8:0] rx_data, rx_head;
  logic [CNT_W-1:0] rx_count;

  assign tx_push = reg_wr_i && reg_addr_i == A_DATA;
  assign rx_pop  = reg_rd_i && reg_addr_i == A_DATA;

  uart9_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
    .clk_i, .rst_ni, .div_i(div_q), .add_i(add_q), .mul_i(mul_q), .tick_o(tick));

  uart9_fifo #(.W(9), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(reg_wdata_i[8:0]), .pop_i(tx_pop),
    .data_o(tx_head), .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty));

  uart9_tx u_tx (
    .clk_i, .rst_ni, .tick_i(tick), .nine_i(nine_en), .pause_i(tx_pause),
    .valid_i(!tx_empty), .data_i(tx_head), .pop_o(tx_pop), .busy_o(tx_busy), .tx_o);

  uart9_rx u_rx (
    .clk_i, .rst_ni, .tick_i(tick), .nine_i(nine_en), .rx_i,
    .valid_o(rx_valid), .data_o(rx_data), .ferr_o(rx_ferr));

  // address filter sits ahead of the receive queue
  assign is_addr = nine_en && rx_data[8];
  assign keep    = !nine_en || !auto_en || (!is_addr && match_q);
  assign rx_push = rx_valid && keep;

  uart9_fifo #(.W(9), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk_i, .rst_ni, .push_i(rx_push), .data_i(rx_data), .pop_i(rx_pop),
    .data_o(rx_head), .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty));

  assign irq_o = rx_count >= CNT_W'(trig_level(trig_sel));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      node_q  <= '0;
      div_q   <= DIV_W'(1);
      add_q   <= '0;
      mul_q   <= '0;
      ovr_q   <= 1'b0;
      ferr_q  <= 1'b0;
      adr_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_LINE: line_q <= reg_wdata_i[4:0];
          A_NODE: node_q <= reg_wdata_i[7:0];
          A_DIV:  div_q  <= reg_wdata_i[DIV_W-1:0];
          A_FRAC: begin
            add_q <= reg_wdata_i[FRAC_W-1:0];
            mul_q <= reg_wdata_i[2*FRAC_W-1:FRAC_W];
          end
          A_STAT: begin
            if (reg_wdata_i[2]) ovr_q  <= 1'b0;
            if (reg_wdata_i[3]) ferr_q <= 1'b0;
            if (reg_wdata_i[4]) adr_q  <= 1'b0;
          end
          default: ;
        endcase
      end
      // set beats a simultaneous clear
      if (rx_push && rx_full)                 ovr_q   <= 1'b1;
      if (rx_valid && rx_ferr)                ferr_q  <= 1'b1;
      if (rx_valid && is_addr && !auto_en)    adr_q   <= 1'b1;
      if (rx_valid && is_addr && auto_en)     match_q <= (rx_data[7:0] == node_q);
    end
  end

  logic [15:0] stat;
  always_comb begin
    stat = '0;
    stat[0] = !rx_empty;
    stat[1] = tx_full;
    stat[2] = ovr_q;
    stat[3] = ferr_q;
    stat[4] = adr_q;
    stat[5] = tx_empty && !tx_busy;
    stat[8 +: CNT_W] = rx_count;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_DATA: reg_rdata_o[8:0] = rx_head;
      A_LINE: reg_rdata_o[4:0] = line_q;
      A_NODE: reg_rdata_o[7:0] = node_q;
      A_DIV:  reg_rdata_o[DIV_W-1:0] = div_q;
      A_FRAC: reg_rdata_o[2*FRAC_W-1:0] = {mul_q, add_q};
      A_STAT: reg_rdata_o = stat;
      default: ;
    endcase
  end
endmodule

// File: rtl/uart9_core_chk.sv
module uart9_core_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       reg_addr_i,
  input logic             reg_wr_i,
  input logic [15:0]      reg_wdata_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] rx_count,
  input logic             rx_push,
  input logic             rx_pop,
  input logic [8:0]       rx_data,
  input logic             ovr_q,
  input logic             tx_pause,
  input logic             tx_busy,
  input logic             tx_full,
  input logic             tx_pop,
  input logic             auto_en,
  input logic             nine_en
);
  logic ovr_clr;
  assign ovr_clr = reg_wr_i && reg_addr_i == 3'd5 && reg_wdata_i[2];

  assert_rx_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count <= CNT_W'(DEPTH));

  assert_rx_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_push && !rx_pop |=> $stable(rx_count));

  assert_ovr_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q && !ovr_clr |=> ovr_q);

  assert_irq_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count == '0 |-> !irq_o);

  assert_auto_no_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en && nine_en && rx_push |-> !rx_data[8]);

  assert_pause_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pause && !tx_busy |=> !tx_busy);

  assert_tx_full_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full && !tx_pop |=> tx_full);
endmodule

bind uart9_core uart9_core_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .rx_count(rx_count), .rx_push(rx_push),
  .rx_pop(rx_pop), .rx_data(rx_data), .ovr_q(ovr_q), .tx_pause(tx_pause),
  .tx_busy(tx_busy), .tx_full(tx_full), .tx_pop(tx_pop), .auto_en(auto_en),
  .nine_en(nine_en));

// File: tb/uart9_core_bench.sv
module uart9_core_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, tx;
  logic use_drv = 1'b0, drv_line = 1'b1;
  logic rx;
  int checks = 0, errors = 0;
  bit done = 0;

  assign rx = use_drv ? drv_line : tx;

  always #2 clk = ~clk;

  uart9_core u_uart9_core (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .tx_o(tx), .rx_i(rx));

  // bit 9: word expected in queue; bits 8:0: word sent. Node address 0x42.
  localparam logic [9:0] AUTO_VEC [8] = '{
    10'h011, 10'h142, 10'h255, 10'h2AA, 10'h143, 10'h077, 10'h142, 10'h2FF};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, s);
      if (s[5]) break;
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic low_run(output int n);
    @(negedge clk);
    while (tx) @(negedge clk);
    n = 0;
    while (!tx) begin n++; @(negedge clk); end
  endtask

  task automatic capture(input int nbits, output logic [11:0] bits);
    bits = '0;
    @(negedge clk);
    while (tx) @(negedge clk);
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bits[i] = tx;
      if (i != nbits - 1) repeat (16) @(negedge clk);
    end
  endtask

  task automatic drv_frame(input logic [7:0] d, input logic stop_v);
    @(negedge clk);
    drv_line = 1'b0; repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin drv_line = d[i]; repeat (16) @(negedge clk); end
    drv_line = stop_v; repeat (stop_v ? 16 : 12) @(negedge clk);
    drv_line = 1'b1; repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [11:0] bits;
    int n;
    repeat (3) @(negedge clk);
    chk("R1", "tx idle", int'(tx), 1);
    chk("R1", "irq", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "tx after reset", int'(tx), 1);
    chk("R1", "irq after reset", int'(irq), 0);
    rd(3'd5, r); chk("R1", "status", int'(r), 32'h20);

    // R2: 8-bit frame shape and loopback R4
    wr(3'd0, 16'h0A5);
    capture(10, bits);
    chk("R2", "start bit", int'(bits[0]), 0);
    chk("R2", "8-bit data", int'(bits[8:1]), 32'hA5);
    chk("R2", "stop bit", int'(bits[9]), 1);
    wait_done();
    rd(3'd0, r); chk("R4", "loopback 8-bit", int'(r[8:0]), 32'h0A5);

    // R2 nine-bit frame, software filter R9
    wr(3'd1, 16'h0001);
    wr(3'd0, 16'h13C);
    capture(11, bits);
    chk("R2", "9-bit start", int'(bits[0]), 0);
    chk("R2", "9-bit data", int'(bits[9:1]), 32'h13C);
    chk("R2", "9-bit stop", int'(bits[10]), 1);
    wait_done();
    rd(3'd0, r); chk("R9", "address word queued", int'(r[8:0]), 32'h13C);
    wr(3'd0, 16'h012);
    wait_done();
    rd(3'd5, r); chk("R9", "address flag", int'(r[4]), 1);
    rd(3'd0, r); chk("R9", "data word queued", int'(r[8:0]), 32'h012);
    wr(3'd5, 16'h0010);
    rd(3'd5, r); chk("R12", "address flag cleared", int'(r[4]), 0);

    // R2 timing, R3 fractional timing
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h000);
    low_run(n); chk("R2", "low clocks div1", n, 144);
    wait_done(); rd(3'd0, r);
    wr(3'd3, 16'd2);
    wr(3'd4, 16'h21);
    wr(3'd0, 16'h000);
    low_run(n); chk("R3", "low clocks div2 1/2", n, 360);
    wait_done(); rd(3'd0, r);
    wr(3'd3, 16'd1);
    wr(3'd4, 16'h00);

    // R8 table walk: hardware filter
    wr(3'd2, 16'h0042);
    wr(3'd1, 16'h0003);
    foreach (AUTO_VEC[k]) begin
      wr(3'd0, {7'd0, AUTO_VEC[k][8:0]});
      wait_done();
      rd(3'd5, r);
      chk("R8", $sformatf("count after vec %0d", k), int'(r[12:8]), int'(AUTO_VEC[k][9]));
      if (AUTO_VEC[k][9]) begin
        rd(3'd0, r);
        chk("R8", $sformatf("word vec %0d", k), int'(r[8:0]), int'(AUTO_VEC[k][7:0]));
      end
    end

    // R7 interrupt levels
    wr(3'd1, 16'h0008);
    for (int i = 0; i < 3; i++) wr(3'd0, 16'(i + 1));
    wait_done();
    chk("R7", "irq at 3 level 4", int'(irq), 0);
    wr(3'd0, 16'h004);
    wait_done();
    chk("R7", "irq at 4 level 4", int'(irq), 1);
    wr(3'd1, 16'h0018);
    @(negedge clk); chk("R7", "irq at 4 level 14", int'(irq), 0);
    wr(3'd1, 16'h0000);
    @(negedge clk); chk("R7", "irq at 4 level 1", int'(irq), 1);
    for (int i = 0; i < 4; i++) begin
      rd(3'd0, r); chk("R4", "fifo order", int'(r[8:0]), i + 1);
    end
    @(negedge clk); chk("R7", "irq empty", int'(irq), 0);

    // R10 pause, R11 transmit queue depth
    wr(3'd1, 16'h0004);
    for (int i = 0; i < 17; i++) wr(3'd0, 16'(32'h30 + i));
    rd(3'd5, r); chk("R11", "tx full", int'(r[1]), 1);
    n = 0;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!tx) n++; end
    chk("R10", "line low while paused", n, 0);
    rd(3'd5, r); chk("R10", "nothing received while paused", int'(r[12:8]), 0);
    wr(3'd1, 16'h0000);
    wait_done();
    rd(3'd5, r); chk("R11", "words sent", int'(r[12:8]), 16);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, r); chk("R11", "sent word", int'(r[8:0]), 32'h30 + i);
    end
    rd(3'd5, r); chk("R11", "dropped 17th word", int'(r[0]), 0);

    // R5 overrun via serial driver
    use_drv = 1'b1;
    for (int i = 0; i < 17; i++) drv_frame(8'(i + 8'h80), 1'b1);
    rd(3'd5, r);
    chk("R5", "overrun flag", int'(r[2]), 1);
    chk("R4", "queue holds 16", int'(r[12:8]), 16);
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, r); chk("R5", "kept word", int'(r[8:0]), 32'h80 + i);
    end
    wr(3'd5, 16'h0004);
    rd(3'd5, r); chk("R12", "overrun cleared", int'(r[2]), 0);
    chk("R12", "queue empty bit", int'(r[0]), 0);

    // R6 framing error
    drv_frame(8'h5A, 1'b0);
    rd(3'd5, r); chk("R6", "framing flag", int'(r[3]), 1);
    rd(3'd0, r); chk("R6", "word kept", int'(r[8:0]), 32'h5A);
    wr(3'd5, 16'h0008);
    rd(3'd5, r); chk("R12", "framing cleared", int'(r[3]), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule